// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register-and-ALU half of a simple processor in which every storage element meets on one shared internal bus. It holds a bank of general-purpose registers, a program counter, an instruction register, three hidden scratch registers (an ALU operand holder, an ALU result holder and a spare temporary), an address register facing memory and a data register that sits between the internal bus and memory. An external sequencer drives a control word every cycle. The word carries a load and a drive enable for each register, the ALU operation, the choice of ALU first operand, and memory read and write requests. The datapath performs exactly the one transfer that word describes.

Any register-to-register move, ALU step or memory access is a chain of such cycles. The sequencer puts one source on the bus, loads one or more destinations, and may compute a result into the result holder at the same edge. Memory is reached only through the address and data registers. A read or write is held by the sequencer until memory reports ready, and the block raises a wait flag until then.

Top module: `sbus_datapath`

## Requirements
- R1: After reset every register holds zero, except the program counter, which holds parameter RESET_PC (default 0). In the first cycles after reset, the bus therefore reads zero from every source, and mem_addr, mem_wdata and ir_value are zero.
- R2: A register with its load enable at 1 captures the bus value at the next rising edge. With its load enable at 0 it keeps its value, whatever the bus carries.
- R3: bus_value equals the value of the single source whose drive enable is 1, and is zero when no drive enable is set. The sequencer may set at most one drive enable per cycle.
- R4: The ALU first operand is the constant 4 when alu_a_four is 1, else the operand holder (Y). The second operand is the bus value of the same cycle.
- R5: alu_op codes with A the first and B the second operand: 0 A+B, 1 A-B, 2 A&B, 3 A|B, 4 A^B, 5 B, 6 A, 7 B-A. Arithmetic wraps modulo 2^DATA_W.
- R6: The result holder (Z) loads only the ALU result, never the bus directly. The operand holder (Y) loads from the bus and has no bus drive. Its value is visible only through the ALU. The spare temporary loads from and drives the bus like any register.
- R7: The address register loads only from the bus and drives mem_addr continuously.
- R8: The data register loads mem_rdata at an edge where mem_rd and mem_ready are both 1. Otherwise it loads the bus when mdr_in is 1. The memory source wins when both apply.
- R9: mem_wait is 1 exactly while mem_rd or mem_wr is 1 and mem_ready is 0. A read with mem_ready at 0 leaves the data register unchanged.
- R10: mem_wdata always shows the data register.
- R11: ir_value always shows the instruction register, which loads from the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpr_in | input | NUM_GPR | Load enable per general register |
| gpr_out | input | NUM_GPR | Bus drive enable per general register |
| pc_in | input | 1 | Program counter load |
| pc_out | input | 1 | Program counter bus drive |
| ir_in | input | 1 | Instruction register load |
| ir_out | input | 1 | Instruction register bus drive |
| y_in | input | 1 | Operand holder load |
| z_in | input | 1 | Result holder load from ALU |
| z_out | input | 1 | Result holder bus drive |
| tmp_in | input | 1 | Spare temporary load |
| tmp_out | input | 1 | Spare temporary bus drive |
| mar_in | input | 1 | Address register load |
| mdr_in | input | 1 | Data register load from bus |
| mdr_out | input | 1 | Data register bus drive |
| alu_a_four | input | 1 | Select constant 4 as ALU first operand |
| alu_op | input | 3 | ALU operation code |
| mem_rd | input | 1 | Memory read request, held until ready |
| mem_wr | input | 1 | Memory write request, held until ready |
| mem_ready | input | 1 | Memory completion |
| mem_rdata | input | DATA_W | Memory read data |
| mem_addr | output | DATA_W | Memory address (address register) |
| mem_wdata | output | DATA_W | Memory write data (data register) |
| bus_value | output | DATA_W | Current internal bus value |
| ir_value | output | DATA_W | Instruction register to the decoder |
| mem_wait | output | 1 | Memory request pending |

## Verification
The bench runs a fetch sequence that advances the program counter through the constant-4 path while memory withholds ready for two cycles. A datapath that loads the data register without ready, or drops the wait flag early, fetches the wrong instruction. Every ALU code is driven with distinct operand pairs, so a swapped subtract direction or a wrong code decode gives a wrong result. A cycle with both a memory read and a bus load of the data register shows whether memory keeps priority, and cycles with no drive enable show whether the bus floats to a stale value instead of zero. Registers are read back long after unrelated loads, which exposes a load gate tied to the wrong enable.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
    typedef enum logic [2:0] {
        ALU_ADD   = 3'd0,
        ALU_SUB   = 3'd1,
        ALU_AND   = 3'd2,
        ALU_OR    = 3'd3,
        ALU_XOR   = 3'd4,
        ALU_PASSB = 3'd5,
        ALU_PASSA = 3'd6,
        ALU_RSUB  = 3'd7
    } alu_op_e;

    localparam int unsigned EXTRA_SRC = 5;   // pc, ir, z, tmp, mdr
endpackage

// File: rtl/sbus_reg.sv
module sbus_reg #(
    parameter int unsigned W   = 32,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else if (ld) q <= d;
    end
endmodule

// File: rtl/sbus_bus_mux.sv
module sbus_bus_mux #(
    parameter int unsigned W = 32,
    parameter int unsigned N = 4
) (
    input  logic [N-1:0]        oe,
    input  logic [N-1:0][W-1:0] din,
    output logic [W-1:0]        bus
);
    logic [N-1:0][W-1:0] gated;

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign gated[i] = din[i] & {W{oe[i]}};
    end

    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) bus = bus | gated[i];
    end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] y_val,
    input  logic         sel_four,
    input  logic [W-1:0] b_val,
    input  logic [2:0]   op,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] FOUR = W'(4);
    logic [W-1:0] a_val;
    alu_op_e      op_e;

    assign a_val = sel_four ? FOUR : y_val;
    assign op_e  = alu_op_e'(op);

    always_comb begin
        unique case (op_e)
            ALU_ADD:   res = a_val + b_val;
            ALU_SUB:   res = a_val - b_val;
            ALU_AND:   res = a_val & b_val;
            ALU_OR:    res = a_val | b_val;
            ALU_XOR:   res = a_val ^ b_val;
            ALU_PASSB: res = b_val;
            ALU_PASSA: res = a_val;
            ALU_RSUB:  res = b_val - a_val;
            default:   res = '0;
        endcase
    end
endmodule

// File: rtl/sbus_mem_if.sv
module sbus_mem_if #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus,
    input  logic         mar_in,
    input  logic         mdr_in,
    input  logic         mem_rd,
    input  logic         mem_wr,
    input  logic         mem_ready,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] mar_q,
    output logic [W-1:0] mdr_q,
    output logic         mem_wait
);
    logic         rd_done;
    logic         mdr_ld;
    logic [W-1:0] mdr_d;

    assign rd_done  = mem_rd & mem_ready;
    assign mdr_ld   = rd_done | mdr_in;
    assign mdr_d    = rd_done ? mem_rdata : bus;
    assign mem_wait = (mem_rd | mem_wr) & ~mem_ready;

    sbus_reg #(.W(W)) u_mar (.clk(clk), .rst_n(rst_n), .ld(mar_in), .d(bus),   .q(mar_q));
    sbus_reg #(.W(W)) u_mdr (.clk(clk), .rst_n(rst_n), .ld(mdr_ld), .d(mdr_d), .q(mdr_q));
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int unsigned NUM_GPR  = 4,
    parameter int unsigned DATA_W   = 32,
    parameter logic [DATA_W-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GPR-1:0] gpr_in,
    input  logic [NUM_GPR-1:0] gpr_out,
    input  logic               pc_in,
    input  logic               pc_out,
    input  logic               ir_in,
    input  logic               ir_out,
    input  logic               y_in,
    input  logic               z_in,
    input  logic               z_out,
    input  logic               tmp_in,
    input  logic               tmp_out,
    input  logic               mar_in,
    input  logic               mdr_in,
    input  logic               mdr_out,
    input  logic               alu_a_four,
    input  logic [2:0]         alu_op,
    input  logic               mem_rd,
    input  logic               mem_wr,
    input  logic               mem_ready,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [DATA_W-1:0]  bus_value,
    output logic [DATA_W-1:0]  ir_value,
    output logic               mem_wait
);
    localparam int unsigned NSRC    = NUM_GPR + EXTRA_SRC;
    localparam int unsigned IDX_PC  = NUM_GPR;
    localparam int unsigned IDX_IR  = NUM_GPR + 1;
    localparam int unsigned IDX_Z   = NUM_GPR + 2;
    localparam int unsigned IDX_TMP = NUM_GPR + 3;
    localparam int unsigned IDX_MDR = NUM_GPR + 4;

    logic [NSRC-1:0]             src_oe;
    logic [NSRC-1:0][DATA_W-1:0] src_data;
    logic [DATA_W-1:0]           bus;
    logic [DATA_W-1:0]           pc_q, ir_q, y_q, z_q, tmp_q, mar_q, mdr_q, alu_res;

    assign src_oe = {mdr_out, tmp_out, z_out, ir_out, pc_out, gpr_out};

    for (genvar i = 0; i < NUM_GPR; i++) begin : g_gpr
        logic [DATA_W-1:0] q;
        sbus_reg #(.W(DATA_W)) u_r (.clk(clk), .rst_n(rst_n), .ld(gpr_in[i]), .d(bus), .q(q));
        assign src_data[i] = q;
    end

    sbus_reg #(.W(DATA_W), .RST(RESET_PC)) u_pc (.clk(clk), .rst_n(rst_n), .ld(pc_in), .d(bus), .q(pc_q));
    sbus_reg #(.W(DATA_W)) u_ir  (.clk(clk), .rst_n(rst_n), .ld(ir_in),  .d(bus),     .q(ir_q));
    sbus_reg #(.W(DATA_W)) u_y   (.clk(clk), .rst_n(rst_n), .ld(y_in),   .d(bus),     .q(y_q));
    sbus_reg #(.W(DATA_W)) u_z   (.clk(clk), .rst_n(rst_n), .ld(z_in),   .d(alu_res), .q(z_q));
    sbus_reg #(.W(DATA_W)) u_tmp (.clk(clk), .rst_n(rst_n), .ld(tmp_in), .d(bus),     .q(tmp_q));

    assign src_data[IDX_PC]  = pc_q;
    assign src_data[IDX_IR]  = ir_q;
    assign src_data[IDX_Z]   = z_q;
    assign src_data[IDX_TMP] = tmp_q;
    assign src_data[IDX_MDR] = mdr_q;

    sbus_bus_mux #(.W(DATA_W), .N(NSRC)) u_bus (.oe(src_oe), .din(src_data), .bus(bus));

    sbus_alu #(.W(DATA_W)) u_alu (
        .y_val(y_q), .sel_four(alu_a_four), .b_val(bus), .op(alu_op), .res(alu_res)
    );

    sbus_mem_if #(.W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .bus(bus), .mar_in(mar_in), .mdr_in(mdr_in),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mar_q(mar_q), .mdr_q(mdr_q), .mem_wait(mem_wait)
    );

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign bus_value = bus;
    assign ir_value  = ir_q;
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NSRC   = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   src_oe,
    input logic [DATA_W-1:0] bus,
    input logic              pc_in,
    input logic [DATA_W-1:0] pc_q,
    input logic              ir_in,
    input logic [DATA_W-1:0] ir_value,
    input logic              mar_in,
    input logic [DATA_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_ready,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              z_in,
    input logic              alu_a_four,
    input logic [2:0]        alu_op,
    input logic [DATA_W-1:0] z_q
);
    p_single_driver_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_oe));

    p_idle_bus_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_oe == '0) |-> (bus == '0));

    p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_in |=> (pc_q == $past(pc_q)));

    p_pc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_in |=> (pc_q == $past(bus)));

    p_ir_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ir_in |=> (ir_value == $past(bus)));

    p_mar_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mar_in |=> (mem_addr == $past(bus)));

    p_mdr_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_ready) |=> (mem_wdata == $past(mem_rdata)));

    p_z_incr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (z_in && alu_a_four && alu_op == 3'd0) |=> (z_q == $past(bus) + DATA_W'(4)));
endmodule

bind sbus_datapath sbus_datapath_chk #(.DATA_W(DATA_W), .NSRC(NSRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_oe(src_oe), .bus(bus),
    .pc_in(pc_in), .pc_q(pc_q), .ir_in(ir_in), .ir_value(ir_value),
    .mar_in(mar_in), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .z_in(z_in),
    .alu_a_four(alu_a_four), .alu_op(alu_op), .z_q(z_q)
);

// File: tb/tb_sbus_datapath.sv
module tb_sbus_datapath;
    localparam int NG = 4;
    localparam int DW = 32;

    typedef struct packed {
        logic [NG-1:0] gin;
        logic [NG-1:0] gout;
        logic pc_in, pc_out, ir_in, ir_out, y_in, z_in, z_out;
        logic t_in, t_out, mar_in, mdr_in, mdr_out, four;
        logic [2:0] op;
        logic rd, wr, ready;
    } ctl_t;

    typedef struct {
        string         tag;
        logic [DW-1:0] bus, addr, wdata, ir;
        logic          wt;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    ctl_t cw = '0;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] mem_addr, mem_wdata, bus_value, ir_value;
    logic mem_wait;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    exp_t q[$];

    logic [DW-1:0] gpr_m [NG];
    logic [DW-1:0] pc_m, ir_m, y_m, z_m, tmp_m, mar_m, mdr_m;

    always #5 clk = ~clk;

    sbus_datapath #(.NUM_GPR(NG), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .gpr_in(cw.gin), .gpr_out(cw.gout),
        .pc_in(cw.pc_in), .pc_out(cw.pc_out), .ir_in(cw.ir_in), .ir_out(cw.ir_out),
        .y_in(cw.y_in), .z_in(cw.z_in), .z_out(cw.z_out), .tmp_in(cw.t_in), .tmp_out(cw.t_out),
        .mar_in(cw.mar_in), .mdr_in(cw.mdr_in), .mdr_out(cw.mdr_out),
        .alu_a_four(cw.four), .alu_op(cw.op), .mem_rd(cw.rd), .mem_wr(cw.wr),
        .mem_ready(cw.ready), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .bus_value(bus_value), .ir_value(ir_value), .mem_wait(mem_wait)
    );

    function automatic logic [DW-1:0] mem_fn(input logic [DW-1:0] a);
        return (a ^ 32'h3C5A_9E17) * 32'h0000_9E37 + 32'h11;
    endfunction

    // R5 encoding, computed from the requirement
    function automatic logic [DW-1:0] alu_ref(input logic [2:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return b;
            3'd6: return a;
            default: return b - a;
        endcase
    endfunction

    function automatic ctl_t idle();
        ctl_t c;
        c = '0;
        return c;
    endfunction

    task automatic check(input string tag, input string fld, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, fld, act, exp);
        end
    endtask

    // driver: applies one control word and pushes the expected outputs of that cycle
    task automatic run(input ctl_t c, input string tag);
        logic [DW-1:0] b, a, r;
        exp_t e;
        @(negedge clk);
        cw = c;
        mem_rdata = mem_fn(mar_m);
        b = '0;
        for (int i = 0; i < NG; i++) if (c.gout[i]) b = b | gpr_m[i];
        if (c.pc_out)  b = b | pc_m;
        if (c.ir_out)  b = b | ir_m;
        if (c.z_out)   b = b | z_m;
        if (c.t_out)   b = b | tmp_m;
        if (c.mdr_out) b = b | mdr_m;
        e.tag = tag; e.bus = b; e.addr = mar_m; e.wdata = mdr_m; e.ir = ir_m;
        e.wt = (c.rd | c.wr) & ~c.ready;
        q.push_back(e);
        a = c.four ? DW'(4) : y_m;
        r = alu_ref(c.op, a, b);
        for (int i = 0; i < NG; i++) if (c.gin[i]) gpr_m[i] = b;
        if (c.pc_in)  pc_m  = b;
        if (c.ir_in)  ir_m  = b;
        if (c.y_in)   y_m   = b;
        if (c.t_in)   tmp_m = b;
        if (c.mar_in) mar_m = b;
        if (c.z_in)   z_m   = r;
        if (c.rd && c.ready) mdr_m = mem_rdata;
        else if (c.mdr_in)   mdr_m = b;
    endtask

    // monitor: pops expected items and compares them before the next edge
    initial begin : mon
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                e = q.pop_front();
                check(e.tag, "bus_value", bus_value, e.bus);
                check(e.tag, "mem_addr",  mem_addr,  e.addr);
                check(e.tag, "mem_wdata", mem_wdata, e.wdata);
                check(e.tag, "ir_value",  ir_value,  e.ir);
                check(e.tag, "mem_wait",  {{(DW-1){1'b0}}, mem_wait}, {{(DW-1){1'b0}}, e.wt});
            end
        end
    end

    task automatic fetch(input int wait_cycles);
        ctl_t c;
        c = idle(); c.pc_out = 1; c.mar_in = 1; c.four = 1; c.op = 3'd0; c.z_in = 1;
        run(c, "R4 fetch pc+4");
        for (int k = 0; k < wait_cycles; k++) begin
            c = idle(); c.rd = 1; c.ready = 0;
            run(c, "R9 read wait");
        end
        c = idle(); c.rd = 1; c.ready = 1;
        run(c, "R8 read done");
        c = idle(); c.z_out = 1; c.pc_in = 1;
        run(c, "R6 z to pc");
        c = idle(); c.mdr_out = 1; c.ir_in = 1;
        run(c, "R11 mdr to ir");
        c = idle(); c.ir_out = 1;
        run(c, "R11 ir readback");
    endtask

    task automatic mem_to_gpr(input int i);
        ctl_t c;
        c = idle(); c.rd = 1; c.ready = 1;
        run(c, "R8 load word");
        c = idle(); c.mdr_out = 1; c.gin[i] = 1'b1;
        run(c, "R2 mdr to gpr");
        c = idle(); c.mdr_out = 1; c.mar_in = 1;
        run(c, "R7 new address");
    endtask

    initial begin : wdog
        #(200000 * 10);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        ctl_t c;
        for (int i = 0; i < NG; i++) gpr_m[i] = '0;
        pc_m = '0; ir_m = '0; y_m = '0; z_m = '0; tmp_m = '0; mar_m = '0; mdr_m = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every source reads its reset value
        for (int i = 0; i < NG; i++) begin
            c = idle(); c.gout[i] = 1'b1;
            run(c, "R1 gpr reset");
        end
        c = idle(); c.pc_out = 1;  run(c, "R1 pc reset");
        c = idle(); c.ir_out = 1;  run(c, "R1 ir reset");
        c = idle(); c.z_out = 1;   run(c, "R1 z reset");
        c = idle(); c.t_out = 1;   run(c, "R1 tmp reset");
        c = idle(); c.mdr_out = 1; run(c, "R1 mdr reset");
        c = idle();                run(c, "R3 idle bus zero");

        // fetch harness with memory wait states
        fetch(2);
        fetch(0);
        fetch(1);
        c = idle(); c.pc_out = 1; run(c, "R2 pc after fetches");

        for (int i = 0; i < NG; i++) mem_to_gpr(i);

        // R5: every ALU code, two operand orders
        for (int op = 0; op < 8; op++) begin
            for (int sw = 0; sw < 2; sw++) begin
                c = idle(); c.gout[sw] = 1'b1; c.y_in = 1;
                run(c, "R6 y load");
                c = idle(); c.gout[1-sw] = 1'b1; c.op = 3'(op); c.z_in = 1;
                run(c, "R5 alu compute");
                c = idle(); c.z_out = 1;
                run(c, "R5 alu result");
            end
        end
        c = idle(); c.gout[2] = 1'b1; c.four = 1; c.op = 3'd1; c.z_in = 1;
        run(c, "R4 four minus bus");
        c = idle(); c.z_out = 1; c.gin[3] = 1'b1;
        run(c, "R4 result to gpr");
        c = idle(); c.gout[3] = 1'b1;
        run(c, "R2 gpr readback");

        // R6: spare temporary round trip
        c = idle(); c.gout[3] = 1'b1; c.t_in = 1; run(c, "R6 tmp load");
        c = idle(); c.gout[0] = 1'b1; c.gin[1] = 1'b1; run(c, "R2 move");
        c = idle(); c.t_out = 1; c.gin[0] = 1'b1; run(c, "R6 tmp drive");
        c = idle(); c.gout[0] = 1'b1; run(c, "R6 tmp value in gpr");
        c = idle(); c.gout[1] = 1'b1; run(c, "R2 held value");

        // R8: memory wins over bus load, then plain bus load
        c = idle(); c.gout[2] = 1'b1; c.mdr_in = 1; c.rd = 1; c.ready = 1;
        run(c, "R8 memory priority");
        c = idle(); c.mdr_out = 1; run(c, "R8 mdr after both");
        c = idle(); c.gout[2] = 1'b1; c.mdr_in = 1; run(c, "R8 bus load");
        c = idle(); c.mdr_out = 1; run(c, "R8 mdr from bus");
        c = idle(); c.gout[0] = 1'b1; c.rd = 1; c.ready = 0; c.mdr_in = 0;
        run(c, "R9 read no ready");
        c = idle(); c.mdr_out = 1; run(c, "R9 mdr unchanged");

        // R10: write with wait states
        c = idle(); c.gout[1] = 1'b1; c.mar_in = 1; run(c, "R7 address for write");
        c = idle(); c.wr = 1; c.ready = 0; run(c, "R10 write wait");
        c = idle(); c.wr = 1; c.ready = 0; run(c, "R10 write wait");
        c = idle(); c.wr = 1; c.ready = 1; run(c, "R10 write done");
        c = idle(); run(c, "R3 final idle");
        c = idle(); run(c, "R3 final idle");

        @(negedge clk);
        #4;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule